// File: doc/BRIEF.md
# Bit-serial result unloader

This block lives inside a compute core and hands one finished result at a time to a shared collector over a single data wire. The core loads a result (two identifier words plus six hash words) in one cycle. From then on the block shows a low empty flag until the result has been fully shifted out.

The collector reads by pulsing a one-cycle read request while the flag is low. After a fixed, parameterised delay the block drives a single start bit of 1. It then sends the 256-bit payload as sixteen 16-bit words with no gaps. The words go in ascending order and each word goes least significant bit first, so both identifiers precede the hash. Between transfers the wire rests at 0. The collector only has to watch for the first 1 on the wire.

Top module: `bit_serial_unloader`

## Requirements
- R1: While `empty_o` is high, `line_o` is 0; between a read request and the start bit `line_o` is also 0.
- R2: A load (`ld_valid` high) while `empty_o` is high is captured, and `empty_o` is low from the next cycle on.
- R3: A load while `empty_o` is low is ignored, the held result is sent unchanged, and `err_o` goes high on the next cycle and stays high until reset.
- R4: A read request in cycle c, with `empty_o` low and no transfer running, puts the start bit (value 1) on `line_o` in cycle c+HDR_DELAY; HDR_DELAY defaults to 1.
- R5: Exactly 256 payload bits follow the start bit in consecutive cycles, so one transfer occupies 257 cycles of the wire.
- R6: Payload bit i (bit 0 first) is the result bit i: word k occupies bits 16k..16k+15 and within a word bit 0 is sent first.
- R7: The payload is `{ld_hash, ld_ids}`, so the identifiers go before the hash; the second word on the wire, payload bits 31:16, is `ld_ids[31:16]`, the packet identifier field.
- R8: `empty_o` goes high in the cycle after the last payload bit, and `line_o` is 0 in that cycle.
- R9: A synchronous active-high `rst` clears the held result and `err_o`, sets `empty_o` high and drives `line_o` to 0.
- R10: A read request while `empty_o` is high has no effect: `line_o` stays 0 and `empty_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | One-cycle load strobe for a new result |
| ld_ids | input | 64 | Two 32-bit identifiers, sent first |
| ld_hash | input | 192 | Six 32-bit hash words, sent after the identifiers |
| rd_req | input | 1 | One-cycle read request from the collector |
| empty_o | output | 1 | High when no result is held |
| line_o | output | 1 | Serial data wire: idle 0, start bit, payload |
| err_o | output | 1 | Sticky flag for a load attempted while busy |

## Verification
The checker watches the handshake on every cycle. It checks that the wire stays low while empty and that loads into an empty block are accepted. It checks that a busy load raises a sticky error, that a request to an empty block does nothing, and that a start bit is never seen without a prior request. It also measures the frame length, so that the flag returns exactly 257 cycles after the start bit. Only the bench scenarios can show the content of the frame. The scoreboard rebuilds every payload from the loaded identifiers and hash. It compares the payload bit by bit, checks the packet identifier word and the start-bit latency, and checks that a load rejected during a transfer does not corrupt the data.

// File: rtl/sru_pkg.sv
package sru_pkg;
   typedef enum logic [2:0] {
      SRU_EMPTY,
      SRU_FULL,
      SRU_GAP,
      SRU_DATA,
      SRU_TAIL
   } sru_state_e;
endpackage

// File: rtl/sru_store.sv
module sru_store #(
   parameter int ID_W      = 32,
   parameter int NUM_IDS   = 2,
   parameter int HASH_W    = 32,
   parameter int NUM_HASH  = 6,
   parameter bit USE_SHIFT = 1'b1,
   localparam int IDS_W     = ID_W * NUM_IDS,
   localparam int HASHES_W  = HASH_W * NUM_HASH,
   localparam int PAYLOAD_W = IDS_W + HASHES_W,
   localparam int IDX_W     = $clog2(PAYLOAD_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                capture,
   input  logic                advance,
   input  logic [IDX_W-1:0]    bit_idx,
   input  logic [IDS_W-1:0]    ids,
   input  logic [HASHES_W-1:0] hash,
   output logic                cur_bit
);
   logic [PAYLOAD_W-1:0] packed_w;

   // identifiers occupy the low bits so they leave the wire first
   assign packed_w = {hash, ids};

   generate
      if (USE_SHIFT) begin : g_shift
         logic [PAYLOAD_W-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst)
               sh_q <= '0;
            else if (capture)
               sh_q <= packed_w;
            else if (advance)
               sh_q <= {1'b0, sh_q[PAYLOAD_W-1:1]};
         end
         assign cur_bit = sh_q[0];
      end else begin : g_mux
         logic [PAYLOAD_W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (rst)
               hold_q <= '0;
            else if (capture)
               hold_q <= packed_w;
         end
         assign cur_bit = hold_q[bit_idx];
      end
   endgenerate
endmodule

// File: rtl/sru_seq.sv
module sru_seq
   import sru_pkg::*;
#(
   parameter int PAYLOAD_W = 256,
   parameter int HDR_DELAY = 1,
   localparam int IDX_W = $clog2(PAYLOAD_W),
   localparam int GAP_W = (HDR_DELAY > 2) ? $clog2(HDR_DELAY) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_valid,
   input  logic             rd_req,
   output logic             capture,
   output logic             hdr_fire,
   output logic             shift_fire,
   output logic [IDX_W-1:0] bit_idx,
   output logic             empty_q,
   output logic             err_q
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_W - 1);
   localparam logic [GAP_W-1:0] GAP_INIT = (HDR_DELAY > 1) ? GAP_W'(HDR_DELAY - 2) : '0;

   sru_state_e       st_q;
   logic [GAP_W-1:0] gap_q;
   logic [IDX_W-1:0] idx_q;
   logic             direct_hdr;

   assign direct_hdr = (HDR_DELAY == 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= SRU_EMPTY;
         gap_q   <= '0;
         idx_q   <= '0;
         empty_q <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         if (ld_valid && st_q != SRU_EMPTY)
            err_q <= 1'b1;
         unique case (st_q)
            SRU_EMPTY: if (ld_valid) begin
               st_q    <= SRU_FULL;
               empty_q <= 1'b0;
            end
            SRU_FULL: if (rd_req) begin
               idx_q <= '0;
               if (direct_hdr)
                  st_q <= SRU_DATA;
               else begin
                  gap_q <= GAP_INIT;
                  st_q  <= SRU_GAP;
               end
            end
            SRU_GAP: begin
               if (gap_q == '0)
                  st_q <= SRU_DATA;
               else
                  gap_q <= gap_q - 1'b1;
            end
            SRU_DATA: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX)
                  st_q <= SRU_TAIL;
            end
            SRU_TAIL: begin
               st_q    <= SRU_EMPTY;
               empty_q <= 1'b1;
            end
            default: st_q <= SRU_EMPTY;
         endcase
      end
   end

   assign capture    = (st_q == SRU_EMPTY) && ld_valid;
   assign hdr_fire   = ((st_q == SRU_FULL) && rd_req && direct_hdr) ||
                       ((st_q == SRU_GAP) && (gap_q == '0));
   assign shift_fire = (st_q == SRU_DATA);
   assign bit_idx    = idx_q;
endmodule

// File: rtl/sru_line.sv
module sru_line (
   input  logic clk,
   input  logic rst,
   input  logic hdr_fire,
   input  logic shift_fire,
   input  logic data_bit,
   output logic line_q
);
   always_ff @(posedge clk) begin
      if (rst)
         line_q <= 1'b0;
      else if (hdr_fire)
         line_q <= 1'b1;
      else if (shift_fire)
         line_q <= data_bit;
      else
         line_q <= 1'b0;
   end
endmodule

// File: rtl/bit_serial_unloader.sv
module bit_serial_unloader #(
   parameter int ID_W      = 32,
   parameter int NUM_IDS   = 2,
   parameter int HASH_W    = 32,
   parameter int NUM_HASH  = 6,
   parameter int WORD_W    = 16,
   parameter int HDR_DELAY = 1,
   parameter bit USE_SHIFT = 1'b1,
   localparam int IDS_W     = ID_W * NUM_IDS,
   localparam int HASHES_W  = HASH_W * NUM_HASH,
   localparam int PAYLOAD_W = IDS_W + HASHES_W,
   localparam int IDX_W     = $clog2(PAYLOAD_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld_valid,
   input  logic [IDS_W-1:0]    ld_ids,
   input  logic [HASHES_W-1:0] ld_hash,
   input  logic                rd_req,
   output logic                empty_o,
   output logic                line_o,
   output logic                err_o
);
   generate
      if (HDR_DELAY < 1) begin : g_bad_delay
         $error("HDR_DELAY must be at least 1");
      end
      if ((PAYLOAD_W % WORD_W) != 0) begin : g_bad_word
         $error("payload must be a whole number of words");
      end
      if (IDS_W < 2 * WORD_W) begin : g_bad_ids
         $error("identifiers must fill at least two words");
      end
   endgenerate

   logic             capture, hdr_fire, shift_fire, cur_bit;
   logic [IDX_W-1:0] bit_idx;

   sru_seq #(
      .PAYLOAD_W (PAYLOAD_W),
      .HDR_DELAY (HDR_DELAY)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .ld_valid   (ld_valid),
      .rd_req     (rd_req),
      .capture    (capture),
      .hdr_fire   (hdr_fire),
      .shift_fire (shift_fire),
      .bit_idx    (bit_idx),
      .empty_q    (empty_o),
      .err_q      (err_o)
   );

   sru_store #(
      .ID_W      (ID_W),
      .NUM_IDS   (NUM_IDS),
      .HASH_W    (HASH_W),
      .NUM_HASH  (NUM_HASH),
      .USE_SHIFT (USE_SHIFT)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .advance (shift_fire),
      .bit_idx (bit_idx),
      .ids     (ld_ids),
      .hash    (ld_hash),
      .cur_bit (cur_bit)
   );

   sru_line u_line (
      .clk        (clk),
      .rst        (rst),
      .hdr_fire   (hdr_fire),
      .shift_fire (shift_fire),
      .data_bit   (cur_bit),
      .line_q     (line_o)
   );
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
   parameter int PAYLOAD_W = 256,
   localparam int CNT_W = $clog2(PAYLOAD_W + 2)
) (
   input logic clk,
   input logic rst,
   input logic ld_valid,
   input logic rd_req,
   input logic empty_o,
   input logic line_o,
   input logic err_o
);
   logic             in_frame, armed;
   logic [CNT_W-1:0] fcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_frame <= 1'b0;
         armed    <= 1'b0;
         fcnt     <= '0;
      end else begin
         if (rd_req && !empty_o && !in_frame)
            armed <= 1'b1;
         if (!in_frame && !empty_o && line_o) begin
            in_frame <= 1'b1;
            armed    <= 1'b0;
            fcnt     <= CNT_W'(1);
         end else if (in_frame) begin
            fcnt <= fcnt + 1'b1;
            if (empty_o)
               in_frame <= 1'b0;
         end
      end
   end

   p_idle_line_low_r1: assert property (@(posedge clk) disable iff (rst)
      empty_o |-> !line_o);
   p_load_accept_r2: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && empty_o) |=> !empty_o);
   p_busy_load_err_r3: assert property (@(posedge clk) disable iff (rst)
      (ld_valid && !empty_o) |=> err_o);
   p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o);
   p_hdr_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
      (line_o && !in_frame) |-> armed);
   p_frame_len_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(empty_o) |-> (in_frame && fcnt == CNT_W'(PAYLOAD_W + 1)));
   p_empty_req_ignored_r10: assert property (@(posedge clk) disable iff (rst)
      (rd_req && empty_o && !ld_valid) |=> (empty_o && !line_o));
endmodule

bind bit_serial_unloader sru_checker #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ld_valid (ld_valid),
   .rd_req   (rd_req),
   .empty_o  (empty_o),
   .line_o   (line_o),
   .err_o    (err_o)
);

// File: tb/tb_bit_serial_unloader.sv
`timescale 1ns/1ps
module tb_bit_serial_unloader;
   localparam int PW  = 256;
   localparam int HDR = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ld_valid = 1'b0;
   logic [63:0]   ld_ids = '0;
   logic [191:0]  ld_hash = '0;
   logic          rd_req = 1'b0;
   logic          empty_o, line_o, err_o;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, req_cyc = 0, done_cnt = 0;
   bit mon_on = 1'b0;
   logic [PW-1:0] sb[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bit_serial_unloader #(.HDR_DELAY(HDR)) dut (
      .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ids(ld_ids),
      .ld_hash(ld_hash), .rd_req(rd_req), .empty_o(empty_o),
      .line_o(line_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: load one result and push the expected payload
   task automatic load(input logic [PW-1:0] p);
      @(negedge clk);
      ld_ids = p[63:0]; ld_hash = p[PW-1:64]; ld_valid = 1'b1;
      sb.push_back(p);
      @(negedge clk);
      ld_valid = 1'b0;
      chk(empty_o === 1'b0, "R2 empty after load", PW'(empty_o), '0);
   endtask

   task automatic request();
      @(negedge clk);
      rd_req = 1'b1; req_cyc = cyc;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic wait_done(input int target);
      while (done_cnt < target) @(negedge clk);
   endtask

   task automatic xfer(input logic [PW-1:0] p);
      int t;
      t = done_cnt + 1;
      load(p);
      repeat (2) @(negedge clk);
      request();
      wait_done(t);
   endtask

   // monitor: deserialize frames and compare with the scoreboard
   initial begin
      logic [PW-1:0] got, exp;
      forever begin
         @(negedge clk);
         if (mon_on && line_o === 1'b1) begin
            chk(cyc == req_cyc + HDR, "R4 start-bit latency",
                PW'(cyc - req_cyc), PW'(HDR));
            got = '0;
            for (int i = 0; i < PW; i++) begin
               @(negedge clk);
               got[i] = line_o;
               if (i < PW - 1 && empty_o !== 1'b0)
                  chk(1'b0, "R5 empty high mid-frame", PW'(i), PW'(PW));
            end
            exp = (sb.size() > 0) ? sb.pop_front() : '0;
            chk(got === exp, "R5 R6 payload bits", got, exp);
            chk(got[31:16] === exp[31:16], "R7 packet id word",
                PW'(got[31:16]), PW'(exp[31:16]));
            @(negedge clk);
            chk(empty_o === 1'b1 && line_o === 1'b0, "R8 end of frame",
                PW'({empty_o, line_o}), PW'(2'b10));
            done_cnt++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [PW-1:0] p, q;
      int t;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk({empty_o, line_o, err_o} === 3'b100, "R9 reset state",
          PW'({empty_o, line_o, err_o}), PW'(3'b100));
      mon_on = 1'b1;

      // R10: request while empty
      request();
      t = 0;
      repeat (6) begin
         @(negedge clk);
         if (line_o !== 1'b0 || empty_o !== 1'b1) t++;
      end
      chk(t == 0, "R10 request while empty ignored", PW'(t), '0);
      chk(line_o === 1'b0, "R1 idle line", PW'(line_o), '0);

      // word markers: word k = 16'hA500 | k
      for (int k = 0; k < 16; k++) p[k*16 +: 16] = 16'hA500 | 16'(k);
      xfer(p);
      xfer({192'd0, {64{1'b1}}});
      xfer({{192{1'b1}}, 64'd0});
      p = '0; p[0] = 1'b1; p[PW-1] = 1'b1; p[17] = 1'b1;
      xfer(p);
      for (int r = 0; r < 3; r++) begin
         for (int w = 0; w < 8; w++) p[w*32 +: 32] = $urandom;
         xfer(p);
      end

      // R3: loads while busy (held, then in flight) are ignored
      for (int w = 0; w < 8; w++) p[w*32 +: 32] = $urandom;
      q = ~p;
      t = done_cnt + 1;
      load(p);
      @(negedge clk);
      ld_ids = q[63:0]; ld_hash = q[PW-1:64]; ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0;
      chk(err_o === 1'b1, "R3 error on busy load", PW'(err_o), PW'(1));
      request();
      repeat (20) @(negedge clk);
      ld_ids = q[63:0]; ld_hash = q[PW-1:64]; ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0;
      wait_done(t);
      chk(err_o === 1'b1, "R3 error sticky", PW'(err_o), PW'(1));

      // R9: reset clears the error
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk({empty_o, line_o, err_o} === 3'b100, "R9 reset after error",
          PW'({empty_o, line_o, err_o}), PW'(3'b100));
      xfer({8{32'h1234_5678}});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule